// File: doc/BRIEF.md
# Secure Dynamic Cache Way Partitioner

This block divides the ways of a shared set-associative last-level cache between a high-security domain and a low-security domain. The cache reports every access with its domain and whether it missed. Per-domain miss counts gathered over an epoch are used to move at most one way per epoch toward the domain under pressure. The block drives one way-mask per domain; an access may fill or evict only within its own domain's ways.

The split is asymmetric. Low-security ways sit at the bottom of the way range and high-security ways fill the rest. A way handed from the low side to the high side is flushed through a request/acknowledge handshake before the masks change, so no low-security line stays behind in a confidential way. A way handed from the high side to the low side needs no flush. Instead, a one-cycle invalidate pulse tells the cache to drop that way from high-security lookup in the cycle the masks switch. Resizing may happen only on every HOLD-th epoch tick, on a fixed schedule. The low side grows on its own miss count alone, so confidential demand cannot shape how the low side is resized. A static-mode input freezes the split.

Top module: `way_partitioner`

## Requirements
- R1: `lo_mask` and `hi_mask` are disjoint and together cover all WAYS ways. Low ways are the contiguous range starting at way 0. After reset the low side holds INIT_LO ways.
- R2: Each domain always owns at least one way. A move that would leave a domain with zero ways is not made.
- R3: Each domain has a CW-bit miss counter that saturates at 2^CW-1. Both counters clear on `epoch_tick`, and a miss in the tick cycle is not counted.
- R4: A resize decision is taken only on the first epoch tick after reset and on every HOLD-th tick after it. Other ticks never change the masks.
- R5: On a decision tick, if low misses exceed `threshold` and the high side has more than one way, way index (low count) moves to the low side. This choice reads only the low count and takes priority over R6.
- R6: On a decision tick where R5 does not apply, if high misses exceed low misses plus `threshold` and the low side has more than one way, the top low way moves to the high side.
- R7: A low-to-high move raises `flush_req` in the cycle after the tick, with `way_idx` set to the moved way. `flush_req` and `way_idx` hold until `flush_ack`, and both masks keep their old values until then. The masks switch in the cycle after the acknowledge. Only one flush is outstanding at a time.
- R8: A high-to-low move raises no flush. `hi_inval` pulses for one cycle with `way_idx` set to the moved way, in the same cycle the masks switch.
- R9: While `static_mode` is high, no decision is taken and the masks stay fixed.
- R10: A mask changes only through R7 or R8, and by exactly one way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A cache access is reported this cycle |
| acc_hi | input | 1 | 1 = access from the high-security domain, 0 = low |
| acc_miss | input | 1 | 1 = the access missed |
| epoch_tick | input | 1 | Epoch boundary pulse |
| static_mode | input | 1 | Freeze the current split |
| threshold | input | CW | Miss-difference threshold |
| lo_mask | output | WAYS | Ways owned by the low-security domain |
| hi_mask | output | WAYS | Ways owned by the high-security domain |
| flush_req | output | 1 | Request to flush the low lines in way `way_idx` |
| flush_ack | input | 1 | Cache has finished the requested flush |
| way_idx | output | $clog2(WAYS) | Way being flushed or invalidated |
| hi_inval | output | 1 | Drop way `way_idx` from high-security lookup |

## Verification
The bench builds the block with four ways, two per side at reset, 4-bit counters and a hold of two epochs. With four ways, a single move in either direction reaches the one-way floor of R2 within a few epochs. The 4-bit counters let a burst of twenty misses show saturation against a threshold of 14, where a wrapped count would stay below the threshold. A hold of two alternates decision and idle epochs, so R4 is exercised on every other row of the stimulus table.

// File: rtl/way_partitioner.sv
module way_partitioner #(
  parameter int WAYS    = 16,
  parameter int CW      = 16,
  parameter int HOLD    = 4,
  parameter int INIT_LO = 8,
  localparam int WW     = $clog2(WAYS),
  localparam int NW     = $clog2(WAYS + 1),
  localparam int EW     = (HOLD > 1) ? $clog2(HOLD) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_hi,
  input  logic            acc_miss,
  input  logic            epoch_tick,
  input  logic            static_mode,
  input  logic [CW-1:0]   threshold,
  output logic [WAYS-1:0] lo_mask,
  output logic [WAYS-1:0] hi_mask,
  output logic            flush_req,
  input  logic            flush_ack,
  output logic [WW-1:0]   way_idx,
  output logic            hi_inval
);
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] lo_miss, hi_miss;
  logic [NW-1:0] lo_cnt;
  logic [EW-1:0] ep_cnt;
  logic          decide, grow_lo, grow_hi;

  for (genvar i = 0; i < WAYS; i++) begin : g_mask
    assign lo_mask[i] = (NW'(i) < lo_cnt);
  end
  assign hi_mask = ~lo_mask;

  assign decide  = epoch_tick && (ep_cnt == '0) && !static_mode && !flush_req;
  assign grow_lo = (lo_miss > threshold) && (lo_cnt < NW'(WAYS - 1));
  assign grow_hi = !grow_lo && (lo_cnt > NW'(1)) &&
                   ((CW+1)'(hi_miss) > (CW+1)'(lo_miss) + (CW+1)'(threshold));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_miss <= '0;
      hi_miss <= '0;
    end else if (epoch_tick) begin
      lo_miss <= '0;
      hi_miss <= '0;
    end else if (acc_valid && acc_miss) begin
      if (acc_hi && hi_miss != SAT) hi_miss <= hi_miss + CW'(1);
      if (!acc_hi && lo_miss != SAT) lo_miss <= lo_miss + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ep_cnt <= '0;
    else if (epoch_tick)
      ep_cnt <= (ep_cnt == EW'(HOLD - 1)) ? '0 : ep_cnt + EW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt    <= NW'(INIT_LO);
      flush_req <= 1'b0;
      way_idx   <= '0;
      hi_inval  <= 1'b0;
    end else begin
      hi_inval <= 1'b0;
      if (flush_req) begin
        if (flush_ack) begin
          flush_req <= 1'b0;
          lo_cnt    <= lo_cnt - NW'(1);
        end
      end else if (decide && grow_lo) begin
        lo_cnt   <= lo_cnt + NW'(1);
        hi_inval <= 1'b1;
        way_idx  <= WW'(lo_cnt);
      end else if (decide && grow_hi) begin
        flush_req <= 1'b1;
        way_idx   <= WW'(lo_cnt - NW'(1));
      end
    end
  end
endmodule

module way_partitioner_chk #(
  parameter int WAYS = 16,
  localparam int WW  = $clog2(WAYS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [WAYS-1:0] lo_mask,
  input logic [WAYS-1:0] hi_mask,
  input logic            flush_req,
  input logic            flush_ack,
  input logic [WW-1:0]   way_idx,
  input logic            hi_inval
);
  assert_disjoint_cover_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_mask & hi_mask) == '0) && ((lo_mask | hi_mask) == '1));

  assert_min_one_way_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_mask != '0) && (hi_mask != '0));

  assert_flush_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_ack |=> flush_req && $stable(way_idx));

  assert_masks_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush_req) && !$past(flush_ack) |-> $stable(lo_mask));

  assert_inval_no_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_inval |-> !flush_req);

  assert_change_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lo_mask) |-> hi_inval || ($past(flush_req) && $past(flush_ack)));

  assert_one_way_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lo_mask ^ $past(lo_mask)) <= 1);
endmodule

bind way_partitioner way_partitioner_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lo_mask(lo_mask), .hi_mask(hi_mask),
  .flush_req(flush_req), .flush_ack(flush_ack), .way_idx(way_idx),
  .hi_inval(hi_inval));

// File: tb/test_way_partitioner.sv
module test_way_partitioner;
  localparam int WAYS = 4;
  localparam int CW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_hi = 1'b0, acc_miss = 1'b0;
  logic epoch_tick = 1'b0, static_mode = 1'b0, flush_ack = 1'b0;
  logic [CW-1:0] threshold = 4'd2;
  logic [WAYS-1:0] lo_mask, hi_mask;
  logic flush_req, hi_inval;
  logic [1:0] way_idx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  way_partitioner #(.WAYS(WAYS), .CW(CW), .HOLD(2), .INIT_LO(2)) i_way_partitioner (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hi(acc_hi),
    .acc_miss(acc_miss), .epoch_tick(epoch_tick), .static_mode(static_mode),
    .threshold(threshold), .lo_mask(lo_mask), .hi_mask(hi_mask),
    .flush_req(flush_req), .flush_ack(flush_ack), .way_idx(way_idx),
    .hi_inval(hi_inval));

  // {nlo[16:12], nhi[11:7], lo_mask[6:3], flush[2], way[1:0]}
  localparam logic [16:0] VEC [15] = '{
    {5'd3, 5'd0,  4'b0111, 1'b0, 2'd2},
    {5'd5, 5'd0,  4'b0111, 1'b0, 2'd0},
    {5'd3, 5'd0,  4'b0111, 1'b0, 2'd0},
    {5'd0, 5'd9,  4'b0111, 1'b0, 2'd0},
    {5'd0, 5'd5,  4'b0011, 1'b1, 2'd2},
    {5'd0, 5'd0,  4'b0011, 1'b0, 2'd0},
    {5'd2, 5'd5,  4'b0001, 1'b1, 2'd1},
    {5'd0, 5'd0,  4'b0001, 1'b0, 2'd0},
    {5'd0, 5'd9,  4'b0001, 1'b0, 2'd0},
    {5'd0, 5'd0,  4'b0001, 1'b0, 2'd0},
    {5'd2, 5'd4,  4'b0001, 1'b0, 2'd0},
    {5'd0, 5'd0,  4'b0001, 1'b0, 2'd0},
    {5'd3, 5'd15, 4'b0011, 1'b0, 2'd1},
    {5'd0, 5'd9,  4'b0011, 1'b0, 2'd0},
    {5'd0, 5'd2,  4'b0011, 1'b0, 2'd0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_epoch(input int nlo, input int nhi);
    for (int k = 0; k < nlo; k++) begin
      @(negedge clk); acc_valid = 1; acc_hi = 0; acc_miss = 1;
    end
    for (int k = 0; k < nhi; k++) begin
      @(negedge clk); acc_valid = 1; acc_hi = 1; acc_miss = 1;
    end
    @(negedge clk); acc_valid = 0; epoch_tick = 1;
    @(negedge clk); epoch_tick = 0;
  endtask

  task automatic do_flush(input logic [3:0] old_mask, input int exp_way, input logic [3:0] new_mask);
    check(flush_req == 1, "R7 flush raised", int'(flush_req), 1);
    check(way_idx == 2'(exp_way), "R7 flush way", int'(way_idx), exp_way);
    repeat (2) @(negedge clk);
    check(flush_req == 1 && lo_mask == old_mask, "R7 hold until ack",
          int'(lo_mask), int'(old_mask));
    flush_ack = 1;
    @(negedge clk); flush_ack = 0;
    check(flush_req == 0, "R7 req drops", int'(flush_req), 0);
    check(lo_mask == new_mask, "R7 switch after ack", int'(lo_mask), int'(new_mask));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(lo_mask == 4'b0011, "R1 reset lo_mask", int'(lo_mask), 3);
    check(hi_mask == 4'b1100, "R1 reset hi_mask", int'(hi_mask), 12);
    check(flush_req == 0 && hi_inval == 0, "R7 R8 reset idle", int'(flush_req), 0);

    prev = lo_mask;
    for (int r = 0; r < 15; r++) begin
      logic [16:0] v;
      v = VEC[r];
      run_epoch(int'(v[16:12]), int'(v[11:7]));
      if (v[2]) begin
        check(lo_mask == prev, "R7 old mask during flush", int'(lo_mask), int'(prev));
        do_flush(prev, int'(v[1:0]), v[6:3]);
      end else begin
        check(flush_req == 0, "R4 R5 R9 no flush", int'(flush_req), 0);
        check(lo_mask == v[6:3], "R2 R4 R5 R6 R3 table mask", int'(lo_mask), int'(v[6:3]));
        if (v[6:3] != prev) begin
          check(hi_inval == 1, "R8 inval pulse", int'(hi_inval), 1);
          check(way_idx == v[1:0], "R8 inval way", int'(way_idx), int'(v[1:0]));
          @(negedge clk);
          check(hi_inval == 0, "R8 single pulse", int'(hi_inval), 0);
        end else begin
          check(hi_inval == 0, "R8 no inval", int'(hi_inval), 0);
        end
      end
      check(hi_mask == ~lo_mask, "R1 complement", int'(hi_mask), int'(~lo_mask));
      prev = lo_mask;
    end

    static_mode = 1;
    run_epoch(0, 9);
    check(lo_mask == 4'b0011 && flush_req == 0, "R9 static A", int'(lo_mask), 3);
    run_epoch(5, 0);
    check(lo_mask == 4'b0011 && hi_inval == 0, "R9 static B", int'(lo_mask), 3);
    static_mode = 0;

    run_epoch(0, 0);
    threshold = 4'd14;
    run_epoch(0, 20);
    check(flush_req == 1, "R3 saturated count triggers", int'(flush_req), 1);
    do_flush(4'b0011, 1, 4'b0001);
    check(hi_mask == 4'b1110, "R2 R6 final hi", int'(hi_mask), 14);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule